// File: doc/BRIEF.md
# Byte-Framed Serial Register Control Port

This block is the slave end of a four-wire control link through which a host microcontroller reaches a 128-byte internal register file. The host drives a serial clock, a data input and an active-low chip select. The block returns read data on a serial output that has its own enable, so an outside buffer can float the line and the input and output can share one wire. Chip select frames every byte on its own. A transaction is a chain of such bytes: an instruction byte first, then the number of data bytes that the instruction implies.

All serial wires are brought into the system clock domain and their edges are detected there. For this reason the serial clock may run all the time or only during bytes. A built-in table gives the length of each instruction. The block checks for missing data bytes with a timeout counted in system clock cycles, for bytes with the wrong clock count, and for unknown instructions. Each of these sets its own bit in a cause register. That register clears when it is read, and it drives a maskable interrupt.

Top module: `ctl_port`

## Requirements
- R1: An instruction byte has the direction in bit 7 (1 = read, 0 = write) and the identifier in bits 6..0. All bytes are shifted most significant bit first, and data in is sampled on the rising serial clock edge.
- R2: Identifiers 0x40..0x5F are 16-bit registers that hold file bytes 2*id-64 (low) and 2*id-63 (high). On both read and write, the first data byte after the instruction byte is the low byte.
- R3: Chip select low frames exactly one byte. If chip select rises after any count of rising clocks other than 8, the byte is discarded, cause bit 2 is set and any open instruction is abandoned.
- R4: The serial output enable is high only from the end of a read instruction byte until its last data byte ends. The output changes only on falling serial clock edges while it is enabled.
- R5: Identifiers 0x00..0x3F are single-byte registers at file byte id. Identifier 0x61 is a 3-bit interrupt enable register, readable and writable, with the value in the low bits of its data byte.
- R6: A write takes effect only when its last data byte is complete. An instruction that is abandoned leaves the target register unchanged.
- R7: If chip select stays high for TIMEOUT_CYC system cycles while an instruction waits for a data byte, the instruction is abandoned and cause bit 0 is set.
- R8: Identifier 0x60 is undefined for writes. So are 0x62..0x7D in either direction. An undefined identifier sets cause bit 1 and expects no data bytes.
- R9: Identifier 0x60 read returns the cause register (bits 2..0) and clears it. irq is high exactly when some cause bit is set and its enable bit in 0x61 is set.
- R10: Identifier 0x7E clears the cause register and 0x7F clears the whole register file. Both consist of the instruction byte alone, whatever the direction bit.
- R11: Serial clock edges while chip select is high have no effect.
- R12: After reset, the register file, cause and enable registers are zero, irq is low and the output enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock from host |
| sdi | input | 1 | Serial data from host |
| cs_n | input | 1 | Active-low byte frame select |
| sdo | output | 1 | Serial read data |
| sdo_oe | output | 1 | Enable for the external output driver |
| irq | output | 1 | Maskable interrupt request |

## Verification
The assertions assume that each serial clock phase and each chip select level lasts several system cycles longer than the synchronizer delay. They also assume that chip select stays high for some cycles after each byte, so that an edge is never missed and the output enable rises while chip select is still high. The bench holds each serial clock phase for six system cycles and leaves ten idle cycles between bytes. It also never moves chip select and the serial clock in the same cycle.

// File: rtl/ctl_pkg.sv
package ctl_pkg;
    localparam int ID_W    = 7;
    localparam int BYTE_W  = 8;
    localparam int CAUSE_W = 3;
    localparam int CB_TMO  = 0;
    localparam int CB_UND  = 1;
    localparam int CB_FRM  = 2;

    localparam logic [ID_W-1:0] ID_CAUSE = 7'h60;
    localparam logic [ID_W-1:0] ID_MASK  = 7'h61;
    localparam logic [ID_W-1:0] ID_CLRC  = 7'h7E;
    localparam logic [ID_W-1:0] ID_CLRR  = 7'h7F;

    typedef enum logic [2:0] {
        K_REG1, K_REG2, K_CAUSE, K_MASK, K_CLRC, K_CLRR, K_BAD
    } kind_e;
endpackage

// File: rtl/ctl_sync.sv
module ctl_sync #(
    parameter int W = 3,
    parameter int STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] q
);
    logic [W-1:0] st_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) st_q[s] <= RST_VAL;
            else        st_q[s] <= (s == 0) ? din : st_q[(s == 0) ? 0 : s-1];
        end
    end

    assign q = st_q[STAGES-1];
endmodule

// File: rtl/ctl_decode.sv
module ctl_decode
    import ctl_pkg::*;
(
    input  logic [BYTE_W-1:0] instr,
    output kind_e             kind,
    output logic [1:0]        need,
    output logic [ID_W-1:0]   addr
);
    logic [ID_W-1:0] id;
    logic            rd;

    assign id = instr[ID_W-1:0];
    assign rd = instr[BYTE_W-1];

    always_comb begin
        kind = K_BAD;
        need = 2'd0;
        addr = '0;
        if (!id[6]) begin
            kind = K_REG1;
            need = 2'd1;
            addr = id;
        end else if (id[6:5] == 2'b10) begin
            kind = K_REG2;
            need = 2'd2;
            addr = {1'b1, id[4:0], 1'b0};
        end else if (id == ID_CAUSE && rd) begin
            kind = K_CAUSE;
            need = 2'd1;
        end else if (id == ID_MASK) begin
            kind = K_MASK;
            need = 2'd1;
        end else if (id == ID_CLRC) begin
            kind = K_CLRC;
        end else if (id == ID_CLRR) begin
            kind = K_CLRR;
        end
    end
endmodule

// File: rtl/ctl_regfile.sv
module ctl_regfile #(
    parameter int AW = 7,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          we,
    input  logic          wide,
    input  logic [AW-1:0] waddr,
    input  logic [2*DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [2*DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem_q [DEPTH];
    logic [DW-1:0] mem_d [DEPTH];
    logic [AW-1:0] waddr_hi;
    logic [AW-1:0] raddr_hi;

    assign waddr_hi = waddr + AW'(1);
    assign raddr_hi = raddr + AW'(1);
    assign rdata    = {mem_q[raddr_hi], mem_q[raddr]};

    always_comb begin
        mem_d = mem_q;
        if (clr) begin
            for (int i = 0; i < DEPTH; i++) mem_d[i] = '0;
        end else if (we) begin
            mem_d[waddr] = wdata[DW-1:0];
            if (wide) mem_d[waddr_hi] = wdata[2*DW-1:DW];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else begin
            mem_q <= mem_d;
        end
    end
endmodule

// File: rtl/ctl_port.sv
module ctl_port
    import ctl_pkg::*;
#(
    parameter int TIMEOUT_CYC = 4096,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    input  logic sdi,
    input  logic cs_n,
    output logic sdo,
    output logic sdo_oe,
    output logic irq
);
    localparam int TW = $clog2(TIMEOUT_CYC + 1);
    localparam int OW = 2 * BYTE_W;

    typedef struct packed {
        logic                busy;
        logic                rd;
        kind_e               kind;
        logic [ID_W-1:0]     addr;
        logic [1:0]          need;
        logic [1:0]          got;
        logic [BYTE_W-1:0]   sh;
        logic [3:0]          bits;
        logic [BYTE_W-1:0]   lo;
        logic [OW-1:0]       obuf;
        logic                oe;
        logic [TW-1:0]       tcnt;
        logic [CAUSE_W-1:0]  cause;
        logic [CAUSE_W-1:0]  mask;
        logic                sclk_p;
        logic                cs_p;
    } st_t;

    st_t st_q, st_d;

    logic [2:0]        sync_q;
    logic              sclk_s, sdi_s, cs_s;
    logic              sclk_rise, sclk_fall, cs_rise, cs_fall;
    kind_e             dec_kind;
    logic [1:0]        dec_need;
    logic [ID_W-1:0]   dec_addr;
    logic              rf_clr, rf_we, rf_wide;
    logic [OW-1:0]     rf_wdata, rf_rdata;

    ctl_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
        .clk(clk), .rst_n(rst_n), .din({cs_n, sdi, sclk}), .q(sync_q)
    );

    assign {cs_s, sdi_s, sclk_s} = sync_q;
    assign sclk_rise = sclk_s & ~st_q.sclk_p;
    assign sclk_fall = ~sclk_s & st_q.sclk_p;
    assign cs_rise   = cs_s & ~st_q.cs_p;
    assign cs_fall   = ~cs_s & st_q.cs_p;

    ctl_decode u_dec (
        .instr(st_q.sh), .kind(dec_kind), .need(dec_need), .addr(dec_addr)
    );

    ctl_regfile #(.AW(ID_W), .DW(BYTE_W)) u_rf (
        .clk(clk), .rst_n(rst_n), .clr(rf_clr), .we(rf_we), .wide(rf_wide),
        .waddr(st_q.addr), .wdata(rf_wdata), .raddr(dec_addr), .rdata(rf_rdata)
    );

    always_comb begin
        st_d     = st_q;
        rf_clr   = 1'b0;
        rf_we    = 1'b0;
        rf_wide  = 1'b0;
        rf_wdata = {st_q.sh, st_q.lo};

        st_d.sclk_p = sclk_s;
        st_d.cs_p   = cs_s;

        if (cs_fall) st_d.bits = '0;

        if (!cs_s && sclk_rise) begin
            st_d.sh   = {st_q.sh[BYTE_W-2:0], sdi_s};
            st_d.bits = (st_q.bits == 4'd15) ? 4'd15 : st_q.bits + 4'd1;
        end

        if (!cs_s && sclk_fall && st_q.oe)
            st_d.obuf = {st_q.obuf[OW-2:0], 1'b0};

        if (st_q.busy && cs_s && !cs_rise) begin
            st_d.tcnt = st_q.tcnt + TW'(1);
            if (st_q.tcnt == TW'(TIMEOUT_CYC - 1)) begin
                st_d.cause[CB_TMO] = 1'b1;
                st_d.busy = 1'b0;
                st_d.oe   = 1'b0;
                st_d.tcnt = '0;
            end
        end

        if (cs_rise) begin
            st_d.tcnt = '0;
            if (st_q.bits != 4'd8) begin
                st_d.cause[CB_FRM] = 1'b1;
                st_d.busy = 1'b0;
                st_d.oe   = 1'b0;
            end else if (!st_q.busy) begin
                case (dec_kind)
                    K_BAD:  st_d.cause[CB_UND] = 1'b1;
                    K_CLRC: st_d.cause = '0;
                    K_CLRR: rf_clr = 1'b1;
                    default: begin
                        st_d.busy = 1'b1;
                        st_d.rd   = st_q.sh[BYTE_W-1];
                        st_d.kind = dec_kind;
                        st_d.addr = dec_addr;
                        st_d.need = dec_need;
                        st_d.got  = '0;
                        if (st_q.sh[BYTE_W-1]) begin
                            st_d.oe = 1'b1;
                            case (dec_kind)
                                K_REG1:  st_d.obuf = {rf_rdata[BYTE_W-1:0], {BYTE_W{1'b0}}};
                                K_REG2:  st_d.obuf = {rf_rdata[BYTE_W-1:0], rf_rdata[OW-1:BYTE_W]};
                                K_CAUSE: begin
                                    st_d.obuf  = {{(BYTE_W-CAUSE_W){1'b0}}, st_q.cause, {BYTE_W{1'b0}}};
                                    st_d.cause = '0;
                                end
                                default: st_d.obuf = {{(BYTE_W-CAUSE_W){1'b0}}, st_q.mask, {BYTE_W{1'b0}}};
                            endcase
                        end
                    end
                endcase
            end else begin
                st_d.lo  = st_q.sh;
                st_d.got = st_q.got + 2'd1;
                if (st_q.got + 2'd1 == st_q.need) begin
                    st_d.busy = 1'b0;
                    st_d.oe   = 1'b0;
                    if (!st_q.rd) begin
                        if (st_q.kind == K_MASK) begin
                            st_d.mask = st_q.sh[CAUSE_W-1:0];
                        end else begin
                            rf_we   = 1'b1;
                            rf_wide = (st_q.kind == K_REG2);
                            rf_wdata = (st_q.kind == K_REG2) ? {st_q.sh, st_q.lo}
                                                             : {{BYTE_W{1'b0}}, st_q.sh};
                        end
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.cs_p <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign sdo    = st_q.obuf[OW-1] & st_q.oe;
    assign sdo_oe = st_q.oe;
    assign irq    = |(st_q.cause & st_q.mask);
endmodule

// File: rtl/ctl_port_chk.sv
module ctl_port_chk #(
    parameter int TW = 13,
    parameter int TIMEOUT_CYC = 4096
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cs_n,
    input logic          sdo,
    input logic          sdo_oe,
    input logic          irq,
    input logic          busy,
    input logic          rd,
    input logic          we,
    input logic          sclk_fall,
    input logic [TW-1:0] tcnt,
    input logic [2:0]    cause,
    input logic [2:0]    mask
);
    // R4: the output is only enabled inside an open read instruction
    a_r4_oe_in_read: assert property (@(posedge clk) disable iff (!rst_n)
        sdo_oe |-> (busy && rd));

    // R4: the enabled output moves only after a falling serial clock edge
    a_r4_sdo_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (sdo_oe && $past(sdo_oe) && sdo != $past(sdo)) |-> $past(sclk_fall));

    // R3: the output enable starts between bytes, with chip select high
    a_r3_oe_between_bytes: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sdo_oe) |-> cs_n);

    // R6: the register file is written only by a write instruction that is open
    a_r6_write_in_open_write: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> (busy && !rd));

    // R7: the wait counter never passes its limit
    a_r7_tcnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        tcnt < TW'(TIMEOUT_CYC));

    // R9: an interrupt only rises when the cause or the enables have changed
    a_r9_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> (cause != $past(cause) || mask != $past(mask)));
endmodule

bind ctl_port ctl_port_chk #(.TW(TW), .TIMEOUT_CYC(TIMEOUT_CYC)) u_chk (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sdo(sdo), .sdo_oe(sdo_oe), .irq(irq),
    .busy(st_q.busy), .rd(st_q.rd), .we(rf_we), .sclk_fall(sclk_fall),
    .tcnt(st_q.tcnt), .cause(st_q.cause), .mask(st_q.mask)
);

// File: tb/ctl_port_test.sv
module ctl_port_test;
    localparam int CLK_PERIOD = 10;
    localparam int HALF = 6;
    localparam int GAP = 10;
    localparam int TMO = 200;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0;
    logic sdi = 1'b0;
    logic cs_n = 1'b1;
    logic sdo, sdo_oe, irq;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    ctl_port #(.TIMEOUT_CYC(TMO), .SYNC_STAGES(2)) uut (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .sdi(sdi), .cs_n(cs_n),
        .sdo(sdo), .sdo_oe(sdo_oe), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic xfer(input logic [7:0] b, input int nclk,
                        output logic [7:0] got, output int oecnt);
        got = '0;
        oecnt = 0;
        cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int i = 0; i < nclk; i++) begin
            sdi = (i < 8) ? b[7-i] : 1'b0;
            repeat (HALF) @(negedge clk);
            got = {got[6:0], sdo};
            if (sdo_oe) oecnt++;
            sclk = 1'b1;
            repeat (HALF) @(negedge clk);
            sclk = 1'b0;
        end
        repeat (HALF) @(negedge clk);
        cs_n = 1'b1;
        repeat (GAP) @(negedge clk);
    endtask

    task automatic put(input logic [7:0] b);
        logic [7:0] g;
        int c;
        xfer(b, 8, g, c);
    endtask

    task automatic wr1(input logic [6:0] id, input logic [7:0] v);
        put({1'b0, id});
        put(v);
    endtask

    task automatic rd1(input logic [6:0] id, output logic [7:0] v, output int oe_ins, output int oe_dat);
        logic [7:0] g;
        xfer({1'b1, id}, 8, g, oe_ins);
        xfer(8'h00, 8, v, oe_dat);
    endtask

    task automatic wr2(input logic [6:0] id, input logic [15:0] v);
        put({1'b0, id});
        put(v[7:0]);
        put(v[15:8]);
    endtask

    task automatic rd2(input logic [6:0] id, output logic [15:0] v);
        logic [7:0] g, lo, hi;
        int c;
        xfer({1'b1, id}, 8, g, c);
        xfer(8'h00, 8, lo, c);
        xfer(8'h00, 8, hi, c);
        v = {hi, lo};
    endtask

    function automatic logic [7:0] pat1(input int a);
        return 8'((a * 37 + 11) & 255);
    endfunction

    function automatic logic [15:0] pat2(input int a);
        return 16'((a * 1234 + 5) & 16'hFFFF);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        logic [15:0] w;
        logic [7:0] g;
        int oi, od, c;

        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R12: reset state
        check("R12 irq", irq, 0);
        check("R12 sdo_oe", sdo_oe, 0);
        rd1(7'h61, v, oi, od);
        check("R12 mask", v, 0);
        rd1(7'h60, v, oi, od);
        check("R12 cause", v, 0);
        rd1(7'h05, v, oi, od);
        check("R12 regfile", v, 0);

        // R1 R5: sweep all single-byte registers
        for (int a = 0; a < 64; a++) wr1(7'(a), pat1(a));
        for (int a = 0; a < 64; a++) begin
            rd1(7'(a), v, oi, od);
            check("R1 R5 single register", v, pat1(a));
            if (a == 9) begin
                check("R4 oe low during instruction byte", oi, 0);
                check("R4 oe high during read data", od, 8);
                check("R4 oe low after read", sdo_oe, 0);
            end
        end

        // R2: sweep all word registers, low byte first
        for (int a = 64; a < 96; a++) wr2(7'(a), pat2(a));
        for (int a = 64; a < 96; a++) begin
            rd2(7'(a), w);
            check("R2 word register", w, pat2(a));
        end
        // R2: single registers unaffected by the word writes
        rd1(7'h3F, v, oi, od);
        check("R2 single reg untouched", v, pat1(63));

        // R5: interrupt enable register
        wr1(7'h61, 8'h05);
        rd1(7'h61, v, oi, od);
        check("R5 mask readback", v, 5);
        wr1(7'h61, 8'h00);

        // R8 R9: undefined identifier, clear on read
        put(8'h65);
        check("R9 irq masked", irq, 0);
        rd1(7'h60, v, oi, od);
        check("R8 undefined cause", v, 8'h02);
        rd1(7'h60, v, oi, od);
        check("R9 cleared on read", v, 0);
        // R8: 0x60 write is undefined
        put(8'h60);
        rd1(7'h60, v, oi, od);
        check("R8 write to cause", v, 8'h02);

        // R9: interrupt when enabled, cleared by read
        wr1(7'h61, 8'h07);
        put(8'hF0);
        check("R9 irq raised", irq, 1);
        rd1(7'h60, v, oi, od);
        check("R9 cause value", v, 8'h02);
        check("R9 irq dropped", irq, 0);

        // R3 R6: short data byte abandons the write
        put(8'h05);
        xfer(8'hAA, 5, g, c);
        check("R3 irq on framing", irq, 1);
        rd1(7'h60, v, oi, od);
        check("R3 framing cause", v, 8'h04);
        rd1(7'h05, v, oi, od);
        check("R6 reg unchanged after short byte", v, pat1(5));
        // R3: nine clocks is a framing error too
        put(8'h06);
        xfer(8'h55, 9, g, c);
        rd1(7'h60, v, oi, od);
        check("R3 long byte cause", v, 8'h04);
        rd1(7'h06, v, oi, od);
        check("R3 reg unchanged after long byte", v, pat1(6));
        // R6: word write abandoned after its first data byte
        put(8'h41);
        put(8'h99);
        xfer(8'h77, 4, g, c);
        rd2(7'h41, w);
        check("R6 word unchanged", w, pat2(65));
        rd1(7'h60, v, oi, od);

        // R7: timeout
        put(8'h07);
        repeat (TMO + 20) @(negedge clk);
        check("R7 irq on timeout", irq, 1);
        rd1(7'h60, v, oi, od);
        check("R7 timeout cause", v, 8'h01);
        rd1(7'h07, v, oi, od);
        check("R7 reg unchanged", v, pat1(7));
        // R7: gap below the limit still completes
        put(8'h08);
        repeat (TMO - 50) @(negedge clk);
        put(8'hC3);
        rd1(7'h08, v, oi, od);
        check("R7 near-limit write", v, 8'hC3);
        rd1(7'h60, v, oi, od);
        check("R7 no cause near limit", v, 0);

        // R11: clock edges with chip select high are ignored
        put(8'h09);
        for (int k = 0; k < 5; k++) begin
            sdi = k[0];
            sclk = 1'b1;
            repeat (HALF) @(negedge clk);
            sclk = 1'b0;
            repeat (HALF) @(negedge clk);
        end
        put(8'h3C);
        rd1(7'h09, v, oi, od);
        check("R11 write across idle clocks", v, 8'h3C);
        rd1(7'h60, v, oi, od);
        check("R11 no cause", v, 0);

        // R10: clear cause command, both directions
        put(8'h70);
        check("R10 irq before clear", irq, 1);
        put(8'hFE);
        check("R10 irq after clear", irq, 0);
        rd1(7'h60, v, oi, od);
        check("R10 cause cleared", v, 0);

        // R10: clear register file command, no data bytes
        put(8'h7F);
        rd1(7'h03, v, oi, od);
        check("R10 single cleared", v, 0);
        rd2(7'h5F, w);
        check("R10 word cleared", w, 0);
        rd1(7'h61, v, oi, od);
        check("R10 mask kept", v, 7);
        rd1(7'h60, v, oi, od);
        check("R10 no cause from command", v, 0);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule